// File: doc/BRIEF.md
# Multi-mode effective address generator

This block works out where the operand of a register-memory instruction lives. It takes a mode code, two register values (a base and an index), a 16-bit constant field and an access-size code. From these it returns one of three things. For the memory modes it returns an effective address. For the auto-modify modes it also returns a new base-register value and a write enable. For the register and immediate modes it returns the operand value itself, with a flag that marks it as a value and not an address. The register file and the data memory are outside the block.

Most modes finish one cycle after `start_i`. The memory-indirect mode needs a second step. The block asks an external memory port for the word at the base address and holds the request until the data comes back. It then presents that word as the final address. `busy_o` is high from the cycle after an accepted start until the result has been presented.

The controller has three states:
- ST_IDLE: waits for a start.
- ST_FETCH: the memory-indirect read is outstanding.
- ST_RESPOND: the one-cycle result strobe.

The transitions are:
- IDLE→FETCH, on a legal memory-indirect start.
- IDLE→RESPOND, on any other start.
- FETCH→FETCH, while the read data is not yet valid.
- FETCH→RESPOND, when the read data is valid.
- RESPOND→IDLE, always.

Top module: `ea_gen`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `mem_req_o` are 0.
- R2: Mode 0 (register) and mode 1 (immediate) raise `is_value_o` with `done_o`. `value_o` is the base in mode 0 and the sign-extended offset in mode 1. `wb_en_o` stays 0.
- R3: Mode 2 (displacement) gives `ea_o` = base + sign-extended offset.
- R4: Mode 3 (register-indirect) gives `ea_o` = base. Mode 4 (indexed) gives `ea_o` = base + index.
- R5: Mode 5 (direct) gives `ea_o` = the offset field, zero-extended.
- R6: Mode 7 (auto-increment) gives `ea_o` = base, `wb_en_o` = 1 and `wb_data_o` = base + step. The step is 1, 2 or 4 for size codes 0, 1 and 2.
- R7: Mode 8 (auto-decrement) gives `ea_o` = `wb_data_o` = base − step, with `wb_en_o` = 1.
- R8: Mode 6 (memory-indirect) holds `mem_req_o` high with `mem_addr_o` = base until `mem_rvalid_i`. On the next cycle it presents `done_o` with `ea_o` = `mem_rdata_i`. `busy_o` stays high throughout.
- R9: A mode code of 9 to 15, or a size code of 3, gives `done_o` with `illegal_o` = 1, `wb_en_o` = 0 and `ea_o` = 0.
- R10: A start while `busy_o` is high is ignored. The pending result is unchanged.
- R11: `done_o` is a one-cycle pulse. For every mode except memory-indirect it arrives exactly one cycle after the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a calculation (taken only when idle) |
| mode_i | input | 4 | Addressing mode code |
| base_i | input | AW | Base register value |
| index_i | input | AW | Index register value |
| offset_i | input | OFFW | Constant field (immediate, displacement or direct address) |
| size_i | input | 2 | Access size: 0=byte, 1=half, 2=word, 3=illegal |
| busy_o | output | 1 | Calculation in progress |
| done_o | output | 1 | Result strobe |
| ea_o | output | AW | Effective address |
| is_value_o | output | 1 | The result is an operand value, not an address |
| value_o | output | AW | Operand value for register and immediate modes |
| wb_en_o | output | 1 | Write the base register back |
| wb_data_o | output | AW | Write-back value for the base register |
| illegal_o | output | 1 | Mode or size code not supported |
| mem_req_o | output | 1 | Indirect read request |
| mem_addr_o | output | AW | Indirect read address |
| mem_rvalid_i | input | 1 | Indirect read data valid |
| mem_rdata_i | input | AW | Indirect read data |

## Verification
The checker tests the following on every cycle:
- `done_o` lasts exactly one cycle.
- A pending indirect request keeps its address stable until data arrives.
- Returned data becomes the address on the next cycle.
- Write-back never appears together with a value result or an illegal code.
- No request is raised while the block is idle.

Some behaviour is shown only by the bench's scenarios:
- The arithmetic of each mode, including sign extension at negative offsets and the per-size step.
- Latency under several memory response delays.
- Starts ignored while busy.

// File: rtl/ea_pkg.sv
package ea_pkg;

    typedef enum logic [3:0] {
        AM_REG    = 4'd0,
        AM_IMM    = 4'd1,
        AM_DISP   = 4'd2,
        AM_RIND   = 4'd3,
        AM_INDEX  = 4'd4,
        AM_DIRECT = 4'd5,
        AM_MIND   = 4'd6,
        AM_AINC   = 4'd7,
        AM_ADEC   = 4'd8
    } amode_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_FETCH   = 2'd1,
        ST_RESPOND = 2'd2
    } ea_state_e;

    localparam logic [3:0] LAST_MODE = 4'd8;

endpackage

// File: rtl/ea_size_decode.sv
module ea_size_decode #(
    parameter int AW = 32
) (
    input  logic [1:0]    size_i,
    output logic [AW-1:0] step_o,
    output logic          bad_o
);
    always_comb begin
        step_o = '0;
        bad_o  = 1'b0;
        unique case (size_i)
            2'd0:    step_o = AW'(1);
            2'd1:    step_o = AW'(2);
            2'd2:    step_o = AW'(4);
            default: bad_o  = 1'b1;
        endcase
    end
endmodule

// File: rtl/ea_addr_calc.sv
module ea_addr_calc
    import ea_pkg::*;
#(
    parameter int AW   = 32,
    parameter int OFFW = 16
) (
    input  logic [3:0]      mode_i,
    input  logic [AW-1:0]   base_i,
    input  logic [AW-1:0]   index_i,
    input  logic [OFFW-1:0] offset_i,
    input  logic [AW-1:0]   step_i,
    input  logic            size_bad_i,
    output logic [AW-1:0]   ea_o,
    output logic [AW-1:0]   value_o,
    output logic            is_value_o,
    output logic            wb_en_o,
    output logic [AW-1:0]   wb_data_o,
    output logic            indirect_o,
    output logic            illegal_o
);
    localparam int EXTW = AW - OFFW;

    logic [AW-1:0] off_sext;
    logic [AW-1:0] off_zext;
    logic [AW-1:0] base_dec;

    assign off_sext = {{EXTW{offset_i[OFFW-1]}}, offset_i};
    assign off_zext = {{EXTW{1'b0}}, offset_i};
    assign base_dec = base_i - step_i;

    always_comb begin
        ea_o       = '0;
        value_o    = '0;
        is_value_o = 1'b0;
        wb_en_o    = 1'b0;
        wb_data_o  = '0;
        indirect_o = 1'b0;
        illegal_o  = size_bad_i || (mode_i > LAST_MODE);
        if (!illegal_o) begin
            unique case (mode_i)
                AM_REG: begin
                    is_value_o = 1'b1;
                    value_o    = base_i;
                end
                AM_IMM: begin
                    is_value_o = 1'b1;
                    value_o    = off_sext;
                end
                AM_DISP:   ea_o = base_i + off_sext;
                AM_RIND:   ea_o = base_i;
                AM_INDEX:  ea_o = base_i + index_i;
                AM_DIRECT: ea_o = off_zext;
                AM_MIND:   indirect_o = 1'b1;
                AM_AINC: begin
                    ea_o      = base_i;
                    wb_en_o   = 1'b1;
                    wb_data_o = base_i + step_i;
                end
                AM_ADEC: begin
                    ea_o      = base_dec;
                    wb_en_o   = 1'b1;
                    wb_data_o = base_dec;
                end
                default: ea_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
    import ea_pkg::*;
#(
    parameter int AW   = 32,
    parameter int OFFW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [3:0]      mode_i,
    input  logic [AW-1:0]   base_i,
    input  logic [AW-1:0]   index_i,
    input  logic [OFFW-1:0] offset_i,
    input  logic [1:0]      size_i,
    output logic            busy_o,
    output logic            done_o,
    output logic [AW-1:0]   ea_o,
    output logic            is_value_o,
    output logic [AW-1:0]   value_o,
    output logic            wb_en_o,
    output logic [AW-1:0]   wb_data_o,
    output logic            illegal_o,
    output logic            mem_req_o,
    output logic [AW-1:0]   mem_addr_o,
    input  logic            mem_rvalid_i,
    input  logic [AW-1:0]   mem_rdata_i
);
    ea_state_e state_q, state_d;

    logic [AW-1:0] step;
    logic          size_bad;
    logic [AW-1:0] c_ea, c_value, c_wb_data;
    logic          c_is_value, c_wb_en, c_indirect, c_illegal;
    logic          accept;

    logic [AW-1:0] ea_q, value_q, wb_data_q, fetch_addr_q;
    logic          is_value_q, wb_en_q, illegal_q;

    ea_size_decode #(.AW(AW)) size_dec_i (
        .size_i (size_i),
        .step_o (step),
        .bad_o  (size_bad)
    );

    ea_addr_calc #(.AW(AW), .OFFW(OFFW)) calc_i (
        .mode_i     (mode_i),
        .base_i     (base_i),
        .index_i    (index_i),
        .offset_i   (offset_i),
        .step_i     (step),
        .size_bad_i (size_bad),
        .ea_o       (c_ea),
        .value_o    (c_value),
        .is_value_o (c_is_value),
        .wb_en_o    (c_wb_en),
        .wb_data_o  (c_wb_data),
        .indirect_o (c_indirect),
        .illegal_o  (c_illegal)
    );

    assign accept = (state_q == ST_IDLE) && start_i;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = c_indirect ? ST_FETCH : ST_RESPOND;
            end
            ST_FETCH: begin
                if (mem_rvalid_i) state_d = ST_RESPOND;
            end
            ST_RESPOND: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // result and fetch-address registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_q         <= '0;
            value_q      <= '0;
            wb_data_q    <= '0;
            fetch_addr_q <= '0;
            is_value_q   <= 1'b0;
            wb_en_q      <= 1'b0;
            illegal_q    <= 1'b0;
        end else if (accept) begin
            ea_q         <= c_ea;
            value_q      <= c_value;
            wb_data_q    <= c_wb_data;
            fetch_addr_q <= base_i;
            is_value_q   <= c_is_value;
            wb_en_q      <= c_wb_en;
            illegal_q    <= c_illegal;
        end else if (state_q == ST_FETCH && mem_rvalid_i) begin
            ea_q <= mem_rdata_i;
        end
    end

    // outputs
    always_comb begin
        busy_o     = 1'b0;
        done_o     = 1'b0;
        mem_req_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_FETCH: begin
                busy_o    = 1'b1;
                mem_req_o = 1'b1;
            end
            ST_RESPOND: begin
                busy_o = 1'b1;
                done_o = 1'b1;
            end
            default: ;
        endcase
        mem_addr_o = fetch_addr_q;
        ea_o       = ea_q;
        value_o    = value_q;
        is_value_o = is_value_q;
        wb_en_o    = wb_en_q;
        wb_data_o  = wb_data_q;
        illegal_o  = illegal_q;
    end
endmodule

// File: rtl/ea_gen_checker.sv
module ea_gen_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy_o,
    input logic          done_o,
    input logic [AW-1:0] ea_o,
    input logic          is_value_o,
    input logic          wb_en_o,
    input logic          illegal_o,
    input logic          mem_req_o,
    input logic [AW-1:0] mem_addr_o,
    input logic          mem_rvalid_i,
    input logic [AW-1:0] mem_rdata_i
);
    assert_idle_no_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mem_req_o);

    assert_value_no_wb_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && is_value_o |-> !wb_en_o);

    assert_req_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o));

    assert_fetch_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && mem_rvalid_i |=> done_o && (ea_o == $past(mem_rdata_i)));

    assert_illegal_no_wb_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && illegal_o |-> !wb_en_o && !is_value_o);

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o && !mem_req_o);
endmodule

bind ea_gen ea_gen_checker #(.AW(AW)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .ea_o         (ea_o),
    .is_value_o   (is_value_o),
    .wb_en_o      (wb_en_o),
    .illegal_o    (illegal_o),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i)
);

// File: tb/ea_gen_tb_top.sv
module ea_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int OFFW = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic [3:0]      mode_i = '0;
    logic [AW-1:0]   base_i = '0;
    logic [AW-1:0]   index_i = '0;
    logic [OFFW-1:0] offset_i = '0;
    logic [1:0]      size_i = '0;
    logic            busy_o, done_o, is_value_o, wb_en_o, illegal_o, mem_req_o;
    logic [AW-1:0]   ea_o, value_o, wb_data_o, mem_addr_o;
    logic            mem_rvalid_i = 1'b0;
    logic [AW-1:0]   mem_rdata_i = '0;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ea_gen #(.AW(AW), .OFFW(OFFW)) dut_i (.*);

    task automatic check(string req, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // behavioural reference: returns expected {illegal, is_value, value, ea, wb_en, wb}
    task automatic model(input int m, input logic [AW-1:0] b, input logic [AW-1:0] x,
                         input logic [OFFW-1:0] o, input int sz,
                         output bit ill, output bit isv, output logic [AW-1:0] val,
                         output logic [AW-1:0] ea, output bit wbe, output logic [AW-1:0] wb);
        longint so;
        logic [AW-1:0] st;
        so  = longint'($signed(o));
        st  = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        ill = (m > 8) || (sz == 3);
        isv = 0; val = 0; ea = 0; wbe = 0; wb = 0;
        if (!ill) begin
            case (m)
                0: begin isv = 1; val = b; end
                1: begin isv = 1; val = AW'(so); end
                2: ea = b + AW'(so);
                3: ea = b;
                4: ea = b + x;
                5: ea = AW'(o);
                7: begin ea = b; wbe = 1; wb = b + st; end
                8: begin ea = b - st; wbe = 1; wb = b - st; end
                default: ;
            endcase
        end
    endtask

    // run one calculation; rdelay and rdata only matter for mode 6
    task automatic run_op(string req, int m, logic [AW-1:0] b, logic [AW-1:0] x,
                          logic [OFFW-1:0] o, int sz, int rdelay,
                          logic [AW-1:0] rdata, bit poke);
        bit ill, isv, wbe;
        logic [AW-1:0] val, ea, wb;
        model(m, b, x, o, sz, ill, isv, val, ea, wbe, wb);
        @(negedge clk);
        start_i = 1; mode_i = 4'(m); base_i = b; index_i = x; offset_i = o; size_i = 2'(sz);
        @(negedge clk);
        if (poke) begin
            start_i = 1; mode_i = 4'd2; base_i = ~b; offset_i = 16'h0100; size_i = 2'd0;
        end else start_i = 0;
        if (m == 6 && !ill) begin
            for (int d = 0; d <= rdelay; d++) begin
                check("R8", "mem_req", AW'(mem_req_o), 1);
                check("R8", "mem_addr", mem_addr_o, b);
                check("R8", "busy", AW'(busy_o), 1);
                check("R11", "early done", AW'(done_o), 0);
                if (d == rdelay) begin mem_rvalid_i = 1; mem_rdata_i = rdata; end
                @(negedge clk);
            end
            mem_rvalid_i = 0;
            mem_rdata_i  = ~rdata;
            ea = rdata;
        end
        start_i = 0;
        check("R11", "done", AW'(done_o), 1);
        check(req, "illegal", AW'(illegal_o), AW'(ill));
        check(req, "is_value", AW'(is_value_o), AW'(isv));
        if (isv) check(req, "value", value_o, val);
        else     check(req, "ea", ea_o, ea);
        check(req, "wb_en", AW'(wb_en_o), AW'(wbe));
        if (wbe) check(req, "wb_data", wb_data_o, wb);
        @(negedge clk);
        check("R11", "done pulse", AW'(done_o), 0);
        check("R10", "busy after", AW'(busy_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "busy", AW'(busy_o), 0);
        check("R1", "done", AW'(done_o), 0);
        check("R1", "mem_req", AW'(mem_req_o), 0);
        rst_n = 1;
        @(negedge clk);

        run_op("R2", 0, 32'h1234_5678, 0, 16'h0000, 2, 0, 0, 0);
        run_op("R2", 1, 0, 0, 16'h8001, 2, 0, 0, 0);
        run_op("R2", 1, 0, 0, 16'h7fff, 0, 0, 0, 0);
        run_op("R3", 2, 32'h0000_1000, 0, 16'h0010, 2, 0, 0, 0);
        run_op("R3", 2, 32'h0000_1000, 0, 16'hfff0, 2, 0, 0, 0);
        run_op("R4", 3, 32'hdead_beef, 0, 16'h5555, 1, 0, 0, 0);
        run_op("R4", 4, 32'hffff_fff0, 32'h20, 16'h0, 2, 0, 0, 0);
        run_op("R5", 5, 32'habcd_0000, 0, 16'hc000, 2, 0, 0, 0);
        for (int s = 0; s < 3; s++) begin
            run_op("R6", 7, 32'h0000_2000, 0, 16'h0, s, 0, 0, 0);
            run_op("R7", 8, 32'h0000_2000, 0, 16'h0, s, 0, 0, 0);
        end
        run_op("R7", 8, 32'h0000_0001, 0, 16'h0, 2, 0, 0, 0);
        run_op("R8", 6, 32'h0000_4000, 0, 16'h0, 2, 0, 32'h1111_2222, 0);
        run_op("R8", 6, 32'h0000_4004, 0, 16'h0, 2, 3, 32'h3333_4444, 0);
        run_op("R10", 6, 32'h0000_4008, 0, 16'h0, 2, 2, 32'h5555_6666, 1);
        run_op("R9", 9, 32'h1, 0, 16'h1, 2, 0, 0, 0);
        run_op("R9", 15, 32'h1, 0, 16'h1, 2, 0, 0, 0);
        run_op("R9", 7, 32'h1, 0, 16'h1, 3, 0, 0, 0);
        run_op("R9", 6, 32'h1, 0, 16'h1, 3, 0, 0, 0);
        finished = 1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (5000) @(posedge clk);
                tests++; fails++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule